// File: doc/BRIEF.md
# SCSI Controller Register Front End

This block is the byte-wide register side of a SCSI bus controller. A host reaches sixteen 8-bit registers through a simple read/write port. The register index is taken from address bits [5:2], so the registers sit at a 4-byte stride and address bits [1:0] are ignored. The block holds a 16-bit transfer count, a byte FIFO, a command register, status, interrupt-reason and sequence-step registers, a configuration byte, a masked option byte and four general bytes. The last of those general bytes carries a fixed chip identifier after reset.

Command bytes written to the command register are decoded on the spot. Bit 7 selects DMA mode. Four low codes (no-op, FIFO flush, chip reset and bus reset) act directly on the registers. Every other code goes out on a one-cycle dispatch strobe to the selection and transfer handlers, which sit outside this block. A selection handler reports its outcome back through a result strobe, and the block then loads the status, reason and sequence codes and raises the interrupt. Reads have side effects: a FIFO read pops a byte, and a read of the interrupt-reason register acknowledges the interrupt.

Top module: `scsi_reg_front`

## Requirements
- R1: After reset every register reads 0x00 except index 14, which reads 0x04. The irq, dma_mode and cmd_valid outputs are low.
- R2: The register index is bus_addr[5:2]. Read data appears on bus_rdata one cycle after bus_rd. Index 0 is the low byte and index 1 the high byte of the transfer count, and both read back as written. When bus_rd and bus_wr are high together, only the write takes effect.
- R3: A write to index 2 pushes a byte into a 16-entry FIFO, and a push into a full FIFO is dropped. A read of index 2 pops bytes in write order and sets irq. A read of index 2 on an empty FIFO returns the last byte popped, or 0x00 if no byte has been popped since reset.
- R4: A write to index 3 stores the byte, which reads back unchanged, and sets dma_mode to bit 7. Any code in bits [6:0] above 0x03 produces a one-cycle cmd_valid pulse, with cmd_code carrying bits [6:0].
- R5: Command 0x01 (flush) loads 0x08 into the reason register (index 5) and 0x00 into the sequence register (index 6). The FIFO contents are kept.
- R6: Command 0x02 returns the whole block, including the FIFO, dma_mode and irq, to the R1 state.
- R7: Command 0x03 (bus reset) loads 0x80 into the reason register. It sets irq only when bit 6 of the configuration register (index 8) is clear.
- R8: A read of index 5 returns the reason byte, clears every status bit (index 4) except bit 4 (0x10), and drops irq.
- R9: A selection result with sel_target of 4 or more, or with sel_present low, loads status 0x80, reason 0x20 and sequence 0x00, and sets irq.
- R10: A selection result for a present target below 4 loads status 0x91, reason 0x18 and sequence 0x04, and sets irq.
- R11: A write to index 11 stores only the bits under mask 0x15. Writes to indices 8 and 12 to 15 are stored as given. Writes to indices 4 to 7, 9 and 10 change nothing, and indices 7, 9 and 10 read 0x00.
- R12: Command 0x00 changes no register other than the command byte itself and dma_mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, takes precedence over bus_rd |
| bus_addr | input | ADDR_W | Byte address; bits [5:2] select the register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Registered interrupt request |
| dma_mode | output | 1 | DMA mode latched from command bit 7 |
| cmd_valid | output | 1 | One-cycle dispatch strobe for handled-elsewhere commands |
| cmd_code | output | 7 | Command code held with the last dispatch |
| sel_done | input | 1 | Selection outcome strobe from the selection handler |
| sel_target | input | TGT_W | Target ID of the finished selection |
| sel_present | input | 1 | High when the selected target exists |

## Verification
A table walk covers the register map. It reads addresses with nonzero bits [1:0] to show the index decode. It pushes three distinct bytes and pops them to show FIFO order. It then pops once more to tell the held value apart from a fresh byte. Directed tests fill the FIFO past 16 entries and read back a rising count, which exposes an overwrite or an off-by-one depth. Bus reset is run with the quiet bit both set and clear. Selections are run with a good target, an out-of-range ID and an absent target, so that each set of loaded codes and the sticky 0x10 status bit after acknowledge can be told apart. Chip reset is issued over dirty state to show that every field returns to its reset value.

// File: rtl/scsi_front_pkg.sv
package scsi_front_pkg;
  localparam int IDX_W = 4;

  localparam logic [IDX_W-1:0] IX_CNT_LO = 4'd0;
  localparam logic [IDX_W-1:0] IX_CNT_HI = 4'd1;
  localparam logic [IDX_W-1:0] IX_FIFO   = 4'd2;
  localparam logic [IDX_W-1:0] IX_CMD    = 4'd3;
  localparam logic [IDX_W-1:0] IX_STAT   = 4'd4;
  localparam logic [IDX_W-1:0] IX_REASON = 4'd5;
  localparam logic [IDX_W-1:0] IX_STEP   = 4'd6;
  localparam logic [IDX_W-1:0] IX_CFG    = 4'd8;
  localparam logic [IDX_W-1:0] IX_OPT    = 4'd11;
  localparam int               AUX_BASE  = 12;
  localparam int               AUX_N     = 4;
  localparam int               AUX_ID    = 2;   // index 14

  localparam logic [6:0] OP_NOP    = 7'h00;
  localparam logic [6:0] OP_FLUSH  = 7'h01;
  localparam logic [6:0] OP_CHIPRS = 7'h02;
  localparam logic [6:0] OP_BUSRS  = 7'h03;

  localparam logic [7:0] ST_INT     = 8'h80;
  localparam logic [7:0] ST_TCOUNT  = 8'h10;
  localparam logic [7:0] ST_DATAIN  = 8'h01;
  localparam logic [7:0] RS_DONE    = 8'h08;
  localparam logic [7:0] RS_SERVICE = 8'h10;
  localparam logic [7:0] RS_DISC    = 8'h20;
  localparam logic [7:0] RS_BUSRS   = 8'h80;
  localparam logic [7:0] STEP_DONE  = 8'h04;
  localparam logic [7:0] ID_VALUE   = 8'h04;
  localparam logic [7:0] OPT_MASK   = 8'h15;
  localparam int         CFG_QUIET  = 6;

  typedef struct packed {
    logic       dma;
    logic       flush;
    logic       chip_rst;
    logic       bus_rst;
    logic       dispatch;
    logic [6:0] code;
  } cmd_dec_t;

  typedef struct packed {
    logic [7:0] status;
    logic [7:0] reason;
    logic [7:0] step;
  } sel_codes_t;
endpackage

// File: rtl/scsi_cmd_decode.sv
module scsi_cmd_decode
  import scsi_front_pkg::*;
(
  input  logic [7:0] cmd_byte,
  output cmd_dec_t   dec
);
  always_comb begin
    dec          = '0;
    dec.dma      = cmd_byte[7];
    dec.code     = cmd_byte[6:0];
    dec.flush    = (cmd_byte[6:0] == OP_FLUSH);
    dec.chip_rst = (cmd_byte[6:0] == OP_CHIPRS);
    dec.bus_rst  = (cmd_byte[6:0] == OP_BUSRS);
    dec.dispatch = (cmd_byte[6:0] > OP_BUSRS);
  end
endmodule

// File: rtl/scsi_sel_result.sv
module scsi_sel_result
  import scsi_front_pkg::*;
#(
  parameter int TGT_W   = 3,
  parameter int MAX_TGT = 4
) (
  input  logic [TGT_W-1:0] sel_target,
  input  logic             sel_present,
  output sel_codes_t       codes
);
  localparam logic [TGT_W:0] LIMIT = MAX_TGT[TGT_W:0];

  logic reachable;
  assign reachable = sel_present && ({1'b0, sel_target} < LIMIT);

  always_comb begin
    if (reachable) begin
      codes.status = ST_INT | ST_TCOUNT | ST_DATAIN;
      codes.reason = RS_SERVICE | RS_DONE;
      codes.step   = STEP_DONE;
    end else begin
      codes.status = ST_INT;
      codes.reason = RS_DISC;
      codes.step   = 8'h00;
    end
  end
endmodule

// File: rtl/scsi_byte_fifo.sv
module scsi_byte_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     head,
  output logic [$clog2(DEPTH):0] count,
  output logic             empty,
  output logic             full
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CAP = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          do_push, do_pop;
  logic [CW-1:0] cnt_n;

  assign empty   = (count == '0);
  assign full    = (count == CAP);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign cnt_n   = count + {{(CW-1){1'b0}}, do_push} - {{(CW-1){1'b0}}, do_pop};
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      count <= cnt_n;
      if (cnt_n == '0) begin
        wptr <= '0;
        rptr <= '0;
      end else begin
        if (do_push) wptr <= wptr + 1'b1;
        if (do_pop)  rptr <= rptr + 1'b1;
      end
    end
  end
endmodule

// File: rtl/scsi_reg_front.sv
module scsi_reg_front
  import scsi_front_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 16,
  parameter int TGT_W      = 3,
  parameter int MAX_TGT    = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq,
  output logic              dma_mode,
  output logic              cmd_valid,
  output logic [6:0]        cmd_code,
  input  logic              sel_done,
  input  logic [TGT_W-1:0]  sel_target,
  input  logic              sel_present
);
  localparam int IDX_LSB = 2;
  localparam int CW      = $clog2(FIFO_DEPTH) + 1;

  logic [IDX_W-1:0] idx;
  logic             wr_acc, rd_acc, soft_clr;
  cmd_dec_t         dec;
  sel_codes_t       sel_codes;

  logic [7:0] cnt_lo, cnt_hi, cmd_q, status_q, reason_q, step_q, cfg_q, opt_q;
  logic [7:0] aux_q [AUX_N];
  logic [7:0] fifo_last, rd_mux;

  logic [7:0]    fifo_head;
  logic [CW-1:0] fifo_count;
  logic          fifo_empty, fifo_full;

  assign idx      = bus_addr[IDX_LSB +: IDX_W];
  assign wr_acc   = bus_wr;
  assign rd_acc   = bus_rd && !bus_wr;
  assign soft_clr = wr_acc && (idx == IX_CMD) && dec.chip_rst;

  scsi_cmd_decode u_dec (
    .cmd_byte (bus_wdata),
    .dec      (dec)
  );

  scsi_sel_result #(.TGT_W(TGT_W), .MAX_TGT(MAX_TGT)) u_sel (
    .sel_target  (sel_target),
    .sel_present (sel_present),
    .codes       (sel_codes)
  );

  scsi_byte_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) u_fifo (
    .clk   (clk),
    .rst   (rst),
    .clr   (soft_clr),
    .push  (wr_acc && (idx == IX_FIFO)),
    .pop   (rd_acc && (idx == IX_FIFO)),
    .din   (bus_wdata),
    .head  (fifo_head),
    .count (fifo_count),
    .empty (fifo_empty),
    .full  (fifo_full)
  );

  // Plain register read view; side-effect reads are handled below.
  always_comb begin
    rd_mux = 8'h00;
    case (idx)
      IX_CNT_LO: rd_mux = cnt_lo;
      IX_CNT_HI: rd_mux = cnt_hi;
      IX_CMD:    rd_mux = cmd_q;
      IX_STAT:   rd_mux = status_q;
      IX_REASON: rd_mux = reason_q;
      IX_STEP:   rd_mux = step_q;
      IX_CFG:    rd_mux = cfg_q;
      IX_OPT:    rd_mux = opt_q;
      default: begin
        if (int'(idx) >= AUX_BASE) rd_mux = aux_q[int'(idx) - AUX_BASE];
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst || soft_clr) begin
      cnt_lo    <= '0;
      cnt_hi    <= '0;
      cmd_q     <= '0;
      status_q  <= '0;
      reason_q  <= '0;
      step_q    <= '0;
      cfg_q     <= '0;
      opt_q     <= '0;
      fifo_last <= '0;
      bus_rdata <= '0;
      irq       <= 1'b0;
      dma_mode  <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_code  <= '0;
      for (int i = 0; i < AUX_N; i++) aux_q[i] <= (i == AUX_ID) ? ID_VALUE : 8'h00;
    end else begin
      cmd_valid <= 1'b0;
      if (wr_acc) begin
        case (idx)
          IX_CNT_LO: cnt_lo <= bus_wdata;
          IX_CNT_HI: cnt_hi <= bus_wdata;
          IX_CMD: begin
            cmd_q    <= bus_wdata;
            dma_mode <= dec.dma;
            if (dec.flush) begin
              reason_q <= RS_DONE;
              step_q   <= 8'h00;
            end
            if (dec.bus_rst) begin
              reason_q <= RS_BUSRS;
              if (!cfg_q[CFG_QUIET]) irq <= 1'b1;
            end
            if (dec.dispatch) begin
              cmd_valid <= 1'b1;
              cmd_code  <= dec.code;
            end
          end
          IX_CFG: cfg_q <= bus_wdata;
          IX_OPT: opt_q <= bus_wdata & OPT_MASK;
          default: begin
            if (int'(idx) >= AUX_BASE) aux_q[int'(idx) - AUX_BASE] <= bus_wdata;
          end
        endcase
      end else if (rd_acc) begin
        case (idx)
          IX_FIFO: begin
            if (!fifo_empty) begin
              bus_rdata <= fifo_head;
              fifo_last <= fifo_head;
              irq       <= 1'b1;
            end else begin
              bus_rdata <= fifo_last;
            end
          end
          IX_REASON: begin
            bus_rdata <= reason_q;
            status_q  <= status_q & ST_TCOUNT;
            irq       <= 1'b0;
          end
          default: bus_rdata <= rd_mux;
        endcase
      end
      if (sel_done) begin
        status_q <= sel_codes.status;
        reason_q <= sel_codes.reason;
        step_q   <= sel_codes.step;
        irq      <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/scsi_reg_front_chk.sv
module scsi_reg_front_chk #(
  parameter int ADDR_W     = 6,
  parameter int FIFO_DEPTH = 16
) (
  input logic                          clk,
  input logic                          rst,
  input logic                          bus_rd,
  input logic                          bus_wr,
  input logic [ADDR_W-1:0]             bus_addr,
  input logic [7:0]                    bus_wdata,
  input logic                          irq,
  input logic                          dma_mode,
  input logic                          cmd_valid,
  input logic                          sel_done,
  input logic [$clog2(FIFO_DEPTH):0]   fifo_count,
  input logic                          cfg_quiet
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;
  localparam logic [CW-1:0] CAP = CW'(FIFO_DEPTH);

  logic [3:0] ix;
  logic       rd_ok, cmd_wr;
  assign ix     = bus_addr[2 +: 4];
  assign rd_ok  = bus_rd && !bus_wr;
  assign cmd_wr = bus_wr && (ix == 4'd3);

  a_r3_fifo_bounded: assert property (@(posedge clk) disable iff (rst)
    fifo_count <= CAP);

  a_r3_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && ix == 4'd2 && fifo_count == CAP) |=> (fifo_count == CAP));

  a_r3_pop_raises_irq: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && ix == 4'd2 && fifo_count != '0) |=> irq);

  a_r8_ack_drops_irq: assert property (@(posedge clk) disable iff (rst)
    (rd_ok && ix == 4'd5 && !sel_done) |=> !irq);

  a_r4_dispatch_origin: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> $past(cmd_wr && bus_wdata[6:0] > 7'h03));

  a_r4_dma_from_bit7: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[6:0] != 7'h02) |=> (dma_mode == $past(bus_wdata[7])));

  a_r6_chip_reset_clears: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[6:0] == 7'h02) |=> (!irq && !dma_mode && fifo_count == '0));

  a_r7_quiet_bus_reset: assert property (@(posedge clk) disable iff (rst)
    (cmd_wr && bus_wdata[6:0] == 7'h03 && cfg_quiet && !irq && !sel_done) |=> !irq);

  a_r10_selection_irq: assert property (@(posedge clk) disable iff (rst)
    (sel_done && !(cmd_wr && bus_wdata[6:0] == 7'h02)) |=> irq);
endmodule

bind scsi_reg_front scsi_reg_front_chk #(.ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .bus_rd     (bus_rd),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .irq        (irq),
  .dma_mode   (dma_mode),
  .cmd_valid  (cmd_valid),
  .sel_done   (sel_done),
  .fifo_count (fifo_count),
  .cfg_quiet  (cfg_q[6])
);

// File: tb/scsi_reg_front_bench.sv
module scsi_reg_front_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_rd = 1'b0, bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, dma_mode, cmd_valid;
  logic [6:0] cmd_code;
  logic       sel_done = 1'b0;
  logic [2:0] sel_target = '0;
  logic       sel_present = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  scsi_reg_front u_scsi_reg_front (
    .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .dma_mode(dma_mode),
    .cmd_valid(cmd_valid), .cmd_code(cmd_code), .sel_done(sel_done),
    .sel_target(sel_target), .sel_present(sel_present)
  );

  // Vector: {req[3:0], wr, addr[5:0], data[7:0], check}; for reads data is the expected value.
  localparam int NV = 33;
  localparam logic [19:0] VEC [NV] = '{
    {4'd1, 1'b0, 6'd56, 8'h04, 1'b1},  // R1 chip id at index 14
    {4'd1, 1'b0, 6'd0,  8'h00, 1'b1},  // R1
    {4'd1, 1'b0, 6'd20, 8'h00, 1'b1},  // R1
    {4'd2, 1'b1, 6'd0,  8'h34, 1'b0},  // R2 count low
    {4'd2, 1'b1, 6'd5,  8'h12, 1'b0},  // R2 count high, addr bits [1:0] ignored
    {4'd2, 1'b0, 6'd2,  8'h34, 1'b1},
    {4'd2, 1'b0, 6'd7,  8'h12, 1'b1},
    {4'd3, 1'b1, 6'd8,  8'hA1, 1'b0},  // R3 FIFO pushes
    {4'd3, 1'b1, 6'd9,  8'hB2, 1'b0},
    {4'd3, 1'b1, 6'd10, 8'hC3, 1'b0},
    {4'd3, 1'b0, 6'd8,  8'hA1, 1'b1},
    {4'd3, 1'b0, 6'd11, 8'hB2, 1'b1},
    {4'd3, 1'b0, 6'd8,  8'hC3, 1'b1},
    {4'd3, 1'b0, 6'd8,  8'hC3, 1'b1},  // R3 empty pop holds last
    {4'd11, 1'b1, 6'd44, 8'hFF, 1'b0}, // R11 masked option
    {4'd11, 1'b0, 6'd44, 8'h15, 1'b1},
    {4'd11, 1'b1, 6'd32, 8'h40, 1'b0}, // R11 config
    {4'd11, 1'b0, 6'd32, 8'h40, 1'b1},
    {4'd11, 1'b1, 6'd48, 8'h5A, 1'b0},
    {4'd11, 1'b0, 6'd51, 8'h5A, 1'b1},
    {4'd11, 1'b1, 6'd16, 8'hFF, 1'b0}, // R11 status is read-only
    {4'd11, 1'b0, 6'd16, 8'h00, 1'b1},
    {4'd11, 1'b1, 6'd36, 8'h77, 1'b0},
    {4'd11, 1'b0, 6'd36, 8'h00, 1'b1},
    {4'd5, 1'b1, 6'd12, 8'h01, 1'b0},  // R5 flush
    {4'd5, 1'b0, 6'd24, 8'h00, 1'b1},
    {4'd5, 1'b0, 6'd20, 8'h08, 1'b1},
    {4'd7, 1'b1, 6'd12, 8'h03, 1'b0},  // R7 bus reset, quiet bit set
    {4'd7, 1'b0, 6'd20, 8'h80, 1'b1},
    {4'd4, 1'b1, 6'd12, 8'h81, 1'b0},  // R4 flush with DMA bit
    {4'd4, 1'b0, 6'd12, 8'h81, 1'b1},
    {4'd5, 1'b0, 6'd20, 8'h08, 1'b1},
    {4'd11, 1'b0, 6'd28, 8'h00, 1'b1}
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic sel(input logic [2:0] t, input logic p);
    sel_done = 1'b1; sel_target = t; sel_present = p;
    @(negedge clk);
    sel_done = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    do_reset();
    check("R1 irq", {7'd0, irq}, 8'h00);
    check("R1 dma", {7'd0, dma_mode}, 8'h00);
    check("R1 cmd_valid", {7'd0, cmd_valid}, 8'h00);

    for (int i = 0; i < NV; i++) begin
      logic [19:0] v;
      v = VEC[i];
      if (v[15]) wr(v[14:9], v[8:1]);
      else begin
        rd(v[14:9], rv);
        if (v[0]) check($sformatf("R%0d vec %0d", v[19:16], i), rv, v[8:1]);
      end
    end
    check("R4 dma after 0x81", {7'd0, dma_mode}, 8'h01);

    // R3: overfill, then drain in order; last pop held
    do_reset();
    for (int i = 0; i < 17; i++) wr(6'd8, 8'(i));
    for (int i = 0; i < 16; i++) begin
      rd(6'd8, rv);
      check("R3 fifo order", rv, 8'(i));
    end
    rd(6'd8, rv);
    check("R3 full push dropped", rv, 8'd15);
    check("R3 pop irq", {7'd0, irq}, 8'h01);

    // R8: acknowledge
    rd(6'd20, rv);
    check("R8 reason", rv, 8'h00);
    check("R8 irq low", {7'd0, irq}, 8'h00);

    // R7: bus reset with quiet bit clear
    wr(6'd32, 8'h00);
    wr(6'd12, 8'h03);
    check("R7 irq raised", {7'd0, irq}, 8'h01);
    rd(6'd20, rv);
    check("R7 reason", rv, 8'h80);

    // R4: dispatch
    wr(6'd12, 8'h42);
    check("R4 cmd_valid", {7'd0, cmd_valid}, 8'h01);
    check("R4 cmd_code", {1'b0, cmd_code}, 8'h42);
    check("R4 dma low", {7'd0, dma_mode}, 8'h00);
    @(negedge clk);
    check("R4 pulse ends", {7'd0, cmd_valid}, 8'h00);
    wr(6'd12, 8'h90);
    check("R4 cmd_code dma", {1'b0, cmd_code}, 8'h10);
    check("R4 dma high", {7'd0, dma_mode}, 8'h01);

    // R10: good selection
    sel(3'd2, 1'b1);
    check("R10 irq", {7'd0, irq}, 8'h01);
    rd(6'd16, rv); check("R10 status", rv, 8'h91);
    rd(6'd20, rv); check("R10 reason", rv, 8'h18);
    rd(6'd16, rv); check("R8 status keeps 0x10", rv, 8'h10);
    rd(6'd24, rv); check("R10 step", rv, 8'h04);

    // R9: bad target and absent target
    sel(3'd5, 1'b1);
    check("R9 irq", {7'd0, irq}, 8'h01);
    rd(6'd16, rv); check("R9 status", rv, 8'h80);
    rd(6'd20, rv); check("R9 reason", rv, 8'h20);
    rd(6'd24, rv); check("R9 step", rv, 8'h00);
    sel(3'd1, 1'b0);
    rd(6'd20, rv); check("R9 absent reason", rv, 8'h20);
    rd(6'd16, rv); check("R8 status cleared", rv, 8'h00);

    // R12: no-op leaves state
    sel(3'd0, 1'b1);
    wr(6'd12, 8'h00);
    check("R12 irq kept", {7'd0, irq}, 8'h01);
    rd(6'd24, rv); check("R12 step", rv, 8'h04);
    rd(6'd20, rv); check("R12 reason", rv, 8'h18);

    // R2: simultaneous read and write, write wins
    bus_rd = 1'b1;
    wr(6'd8, 8'h66);
    bus_rd = 1'b0;
    rd(6'd8, rv); check("R2 write wins", rv, 8'h66);
    rd(6'd8, rv); check("R2 single push", rv, 8'h66);

    // R6: chip reset over dirty state
    wr(6'd8, 8'hAA);
    wr(6'd32, 8'h55);
    wr(6'd0, 8'h99);
    wr(6'd12, 8'h82);
    check("R6 dma", {7'd0, dma_mode}, 8'h00);
    check("R6 irq", {7'd0, irq}, 8'h00);
    rd(6'd32, rv); check("R6 cfg", rv, 8'h00);
    rd(6'd0,  rv); check("R6 count", rv, 8'h00);
    rd(6'd56, rv); check("R6 chip id", rv, 8'h04);
    rd(6'd8,  rv); check("R6 fifo empty", rv, 8'h00);
    rd(6'd12, rv); check("R6 cmd", rv, 8'h00);
    rd(6'd20, rv); check("R6 reason", rv, 8'h00);

    finish_run();
  end
endmodule